// File: doc/BRIEF.md
# Grid-Select SPI Master

This block is an SPI master for a device with few free pins that still has to reach many slave devices. Slaves sit at the crossings of three line groups: chip-select lines, clock lines and data-out lines, with one data-in line shared by every slave. A device number from the host picks exactly one line from each group. During a transfer the chosen select line is active and the chosen clock line toggles. The chosen data-out line carries the real bits. Other slaves on the same select line see no clock. Other slaves on the same clock line are not selected. Every other data-out line carries a constant filler level, so slaves on the same select and clock line receive only a filler command.

The host gives a device number, a byte count and up to `MAX_BYTES` transmit bytes, then pulses `start`. The block runs one SPI mode-0 transaction: the clock idles low, outgoing data changes after a falling edge, and incoming data is sampled at the rising edge. Each received byte comes back with a one-cycle valid pulse. When the select line has been released, `done` pulses. Requests with a device number or byte count out of range are refused with an error pulse, and no line moves.

Top module: `spim_matrix`

## Requirements
- R1: Device number k (0 to N_SEL*N_CLK*N_MOSI-1, default 0..35) maps to select line k/(N_CLK*N_MOSI), clock line (k/N_MOSI) mod N_CLK and data-out line k mod N_MOSI. Only that select line (active low) goes low during the transaction.
- R2: Only the mapped clock line toggles. It gives exactly 8 rising edges per byte. All other clock lines stay low, and every clock line idles low.
- R3: The mapped data-out line sends tx_data byte 0 (bits 7:0) first, then byte 1 (bits 15:8) and so on, each byte most significant bit first. It changes only while the clock is low. Every other data-out line holds the filler level at all times: all ones when NULL_ONES=1, all zeros when NULL_ONES=0.
- R4: The shared data-in line is sampled on each rising clock edge. Each byte is assembled most significant bit first and presented on rx_byte with a one-cycle rx_valid pulse, in order.
- R5: The select line goes low exactly HALF_DIV system cycles before the first rising clock edge. It stays low at least HALF_DIV cycles after the last falling edge. At most one select line is ever low.
- R6: done pulses once per transaction, in the first cycle with all select lines high. Between two transactions the select lines all stay high for at least 2*HALF_DIV system cycles.
- R7: A start pulse while busy is high has no effect: the running transfer finishes unchanged, no second transaction follows, and err stays low.
- R8: A start with a device number at or above the device count, or with nbytes of 0 or above MAX_BYTES, pulses err for one cycle, one cycle after start. busy stays low, all select lines stay high, all clocks stay low and all data-out lines stay at the filler level.
- R9: Out of reset, all select lines are high, all clocks are low, all data-out lines sit at the filler level, and busy, done, err and rx_valid are low.
- R10: Consecutive rising edges on the mapped clock line are exactly 2*HALF_DIV system cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| dev_idx | input | IDX_W (6) | Device number to address |
| nbytes | input | CNT_W (3) | Number of bytes in the transaction |
| tx_data | input | MAX_BYTES*8 (32) | Transmit bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction or inter-frame gap in progress |
| err | output | 1 | One-cycle pulse for a refused request |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse with each received byte |
| done | output | 1 | One-cycle pulse when select is released |
| cs_n | output | N_SEL (4) | Active-low select lines |
| sclk | output | N_CLK (3) | Clock lines |
| mosi | output | N_MOSI (3) | Data-out lines |
| miso | input | 1 | Shared data-in line |

## Verification
The bench drives inputs and samples outputs on the falling system-clock edge. Every result is therefore judged one register stage after the edge that makes it. An accepted start drops the select line on the next edge. An err pulse is checked at the first falling edge after start, and gone one cycle later. The first rising clock edge is expected exactly HALF_DIV cycles after the select drop, and the next ones 2*HALF_DIV cycles apart. rx_valid is due in the cycle the eighth falling edge of each byte appears. done is due in the same cycle that the select line rises, at least HALF_DIV cycles after the last falling edge. The bench's slave model changes its data-in bit in the sample after it sees a falling edge, so every bit is stable for a full half-period before the rising edge that samples it.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_TRAIL = 3'd4,
        ST_GAP   = 3'd5
    } eng_state_e;

endpackage

// File: rtl/spim_index_dec.sv
module spim_index_dec #(
    parameter int N_SEL  = 4,
    parameter int N_CLK  = 3,
    parameter int N_MOSI = 3,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic [N_SEL-1:0]  sel_oh,
    output logic [N_CLK-1:0]  clk_oh,
    output logic [N_MOSI-1:0] dat_oh
);
    localparam int N_DEV   = N_SEL * N_CLK * N_MOSI;
    localparam int PER_SEL = N_CLK * N_MOSI;

    int k;
    int s_i;
    int c_i;
    int m_i;

    always_comb begin
        k        = int'(idx);
        in_range = (k < N_DEV);
        s_i      = k / PER_SEL;
        c_i      = (k / N_MOSI) % N_CLK;
        m_i      = k % N_MOSI;
        for (int i = 0; i < N_SEL; i++)  sel_oh[i] = in_range && (s_i == i);
        for (int i = 0; i < N_CLK; i++)  clk_oh[i] = in_range && (c_i == i);
        for (int i = 0; i < N_MOSI; i++) dat_oh[i] = in_range && (m_i == i);
    end

endmodule

// File: rtl/spim_shift_eng.sv
module spim_shift_eng
    import spim_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int HALF_DIV  = 2,
    parameter int CNT_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   req_ok,
    input  logic [CNT_W-1:0]       nbytes,
    input  logic [MAX_BYTES*8-1:0] tx_data,
    input  logic                   miso,
    output logic                   accept,
    output logic                   busy,
    output logic                   err,
    output logic                   cs_act,
    output logic                   sck,
    output logic                   mo,
    output logic [7:0]             rx_byte,
    output logic                   rx_valid,
    output logic                   done
);
    localparam int TX_W = MAX_BYTES * 8;
    localparam int HC_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [HC_W-1:0] HC_HALF = HC_W'(HALF_DIV - 1);
    localparam logic [HC_W-1:0] HC_GAP  = HC_W'(2 * HALF_DIV - 1);

    typedef struct packed {
        eng_state_e       st;
        logic [HC_W-1:0]  hc;
        logic [2:0]       bi;
        logic [CNT_W-1:0] byi;
        logic [CNT_W-1:0] nb;
        logic [TX_W-1:0]  tx;
        logic [7:0]       rx;
        logic [7:0]       rxb;
        logic             cs;
        logic             sck;
        logic             mo;
        logic             rxv;
        logic             done;
        logic             err;
    } eng_t;

    eng_t q, d;
    logic [TX_W-1:0] tx_nx;

    always_comb begin
        d       = q;
        d.rxv   = 1'b0;
        d.done  = 1'b0;
        d.err   = 1'b0;
        tx_nx   = q.tx >> 8;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (req_ok) begin
                        d.st  = ST_LEAD;
                        d.cs  = 1'b1;
                        d.hc  = '0;
                        d.tx  = tx_data;
                        d.mo  = tx_data[7];
                        d.bi  = '0;
                        d.byi = '0;
                        d.nb  = nbytes;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_LEAD, ST_LOW: begin
                if (q.hc == HC_HALF) begin
                    d.st  = ST_HIGH;
                    d.hc  = '0;
                    d.sck = 1'b1;
                    d.rx  = {q.rx[6:0], miso};
                end else begin
                    d.hc = q.hc + 1'b1;
                end
            end
            ST_HIGH: begin
                if (q.hc == HC_HALF) begin
                    d.hc  = '0;
                    d.sck = 1'b0;
                    d.st  = ST_LOW;
                    if (q.bi == 3'd7) begin
                        d.rxv = 1'b1;
                        d.rxb = q.rx;
                        d.bi  = '0;
                        if (q.byi == q.nb - CNT_W'(1)) begin
                            d.st = ST_TRAIL;
                        end else begin
                            d.byi = q.byi + CNT_W'(1);
                            d.tx  = tx_nx;
                            d.mo  = tx_nx[7];
                        end
                    end else begin
                        d.bi = q.bi + 3'd1;
                        d.mo = q.tx[3'd6 - q.bi];
                    end
                end else begin
                    d.hc = q.hc + 1'b1;
                end
            end
            ST_TRAIL: begin
                if (q.hc == HC_HALF) begin
                    d.hc   = '0;
                    d.cs   = 1'b0;
                    d.done = 1'b1;
                    d.st   = ST_GAP;
                end else begin
                    d.hc = q.hc + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.hc == HC_GAP) begin
                    d.hc = '0;
                    d.st = ST_IDLE;
                end else begin
                    d.hc = q.hc + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign accept   = (q.st == ST_IDLE) && start && req_ok;
    assign busy     = (q.st != ST_IDLE);
    assign err      = q.err;
    assign cs_act   = q.cs;
    assign sck      = q.sck;
    assign mo       = q.mo;
    assign rx_byte  = q.rxb;
    assign rx_valid = q.rxv;
    assign done     = q.done;

endmodule

// File: rtl/spim_matrix.sv
module spim_matrix #(
    parameter int N_SEL     = 4,
    parameter int N_CLK     = 3,
    parameter int N_MOSI    = 3,
    parameter int MAX_BYTES = 4,
    parameter int HALF_DIV  = 2,
    parameter bit NULL_ONES = 1'b0,
    localparam int N_DEV    = N_SEL * N_CLK * N_MOSI,
    localparam int IDX_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [IDX_W-1:0]       dev_idx,
    input  logic [CNT_W-1:0]       nbytes,
    input  logic [MAX_BYTES*8-1:0] tx_data,
    output logic                   busy,
    output logic                   err,
    output logic [7:0]             rx_byte,
    output logic                   rx_valid,
    output logic                   done,
    output logic [N_SEL-1:0]       cs_n,
    output logic [N_CLK-1:0]       sclk,
    output logic [N_MOSI-1:0]      mosi,
    input  logic                   miso
);
    localparam logic NULL_LVL = NULL_ONES;

    typedef struct packed {
        logic [N_SEL-1:0]  sel;
        logic [N_CLK-1:0]  ck;
        logic [N_MOSI-1:0] dat;
    } route_t;

    route_t route_d, route_q;

    logic              in_range;
    logic              req_ok;
    logic              accept;
    logic              cs_act;
    logic              sck;
    logic              mo;
    logic [N_SEL-1:0]  sel_oh;
    logic [N_CLK-1:0]  clk_oh;
    logic [N_MOSI-1:0] dat_oh;

    spim_index_dec #(
        .N_SEL (N_SEL),
        .N_CLK (N_CLK),
        .N_MOSI(N_MOSI),
        .IDX_W (IDX_W)
    ) u_dec (
        .idx     (dev_idx),
        .in_range(in_range),
        .sel_oh  (sel_oh),
        .clk_oh  (clk_oh),
        .dat_oh  (dat_oh)
    );

    assign req_ok = in_range && (nbytes != '0) && (nbytes <= CNT_W'(MAX_BYTES));

    spim_shift_eng #(
        .MAX_BYTES(MAX_BYTES),
        .HALF_DIV (HALF_DIV),
        .CNT_W    (CNT_W)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .req_ok  (req_ok),
        .nbytes  (nbytes),
        .tx_data (tx_data),
        .miso    (miso),
        .accept  (accept),
        .busy    (busy),
        .err     (err),
        .cs_act  (cs_act),
        .sck     (sck),
        .mo      (mo),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid),
        .done    (done)
    );

    always_comb begin
        route_d = route_q;
        if (accept) begin
            route_d.sel = sel_oh;
            route_d.ck  = clk_oh;
            route_d.dat = dat_oh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) route_q <= '0;
        else        route_q <= route_d;
    end

    for (genvar gs = 0; gs < N_SEL; gs++) begin : g_sel
        assign cs_n[gs] = !(cs_act && route_q.sel[gs]);
    end
    for (genvar gc = 0; gc < N_CLK; gc++) begin : g_clk
        assign sclk[gc] = sck && route_q.ck[gc];
    end
    for (genvar gm = 0; gm < N_MOSI; gm++) begin : g_dat
        assign mosi[gm] = (cs_act && route_q.dat[gm]) ? mo : NULL_LVL;
    end

endmodule

// File: rtl/spim_matrix_chk.sv
module spim_matrix_chk #(
    parameter int N_SEL  = 4,
    parameter int N_CLK  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             err,
    input logic             rx_valid,
    input logic             done,
    input logic [N_SEL-1:0] cs_n,
    input logic [N_CLK-1:0] sclk
);
    // R2: never more than one clock line high
    a_r2_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sclk));

    // R5: never more than one select line low
    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R5: a clock pulse only inside a select window
    a_r5_clock_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (|sclk) |-> !(&cs_n));

    // R6: done only once select is released
    a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n));

    // R8: a refused request leaves the lines quiet
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ((&cs_n) && !busy && !(|sclk)));

    // R7: start while busy never raises err
    a_r7_busy_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !err);

    // R4: received bytes only during a transaction
    a_r4_rx_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

endmodule

bind spim_matrix spim_matrix_chk #(
    .N_SEL(N_SEL),
    .N_CLK(N_CLK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .err     (err),
    .rx_valid(rx_valid),
    .done    (done),
    .cs_n    (cs_n),
    .sclk    (sclk)
);

// File: tb/spim_matrix_tb.sv
module spim_matrix_tb;
    localparam int NS = 4, NC = 3, NM = 3, MB = 4, HD = 2;
    localparam bit NULLV = 1'b1;
    localparam int ND = NS * NC * NM;
    localparam int IW = 6, CW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [IW-1:0]  dev_idx = '0;
    logic [CW-1:0]  nbytes = '0;
    logic [MB*8-1:0] tx_data = '0;
    logic           busy, err, rx_valid, done;
    logic [7:0]     rx_byte;
    logic [NS-1:0]  cs_n;
    logic [NC-1:0]  sclk;
    logic [NM-1:0]  mosi;
    logic           miso = 1'b1;

    spim_matrix #(
        .N_SEL(NS), .N_CLK(NC), .N_MOSI(NM), .MAX_BYTES(MB),
        .HALF_DIV(HD), .NULL_ONES(NULLV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_idx(dev_idx),
        .nbytes(nbytes), .tx_data(tx_data), .busy(busy), .err(err),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .done(done),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int total = 0, bad = 0, cyc = 0, rel_cyc = -1;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit pat_bit(input logic [MB*8-1:0] v, input int j);
        return v[8 * (j / 8) + 7 - (j % 8)];
    endfunction

    task automatic run_xfer(input int idx, input int n, input logic [MB*8-1:0] txv,
                            input logic [MB*8-1:0] pat, input int poke_at, input int poke_idx);
        int s, c, m, rises, rxk, ndone, sb, cs_cyc, lead, last_fall, last_rise, trail;
        int v_clk, v_null, v_hold, v_cs, v_data, v_per;
        logic prev_sck, prev_mo;
        s = idx / (NC * NM); c = (idx / NM) % NC; m = idx % NM;
        rises = 0; rxk = 0; ndone = 0; sb = 0; lead = -1; last_fall = 0; last_rise = 0;
        trail = -1; v_clk = 0; v_null = 0; v_hold = 0; v_cs = 0; v_data = 0; v_per = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        dev_idx = IW'(idx); nbytes = CW'(n); tx_data = txv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cs_cyc = cyc;
        chk(cs_n[s] == 1'b0, "R1", "mapped select low", int'(cs_n[s]), 0);
        if (rel_cyc >= 0)
            chk(cyc - rel_cyc >= 2 * HD, "R6", "select high gap", cyc - rel_cyc, 2 * HD);
        miso = pat_bit(pat, 0);
        prev_sck = sclk[c]; prev_mo = mosi[m];
        for (int k = 0; k < 4000; k++) begin
            if (k == poke_at && poke_at > 0) begin
                start = 1'b1; dev_idx = IW'(poke_idx);
            end else begin
                start = 1'b0;
            end
            for (int i = 0; i < NS; i++) if (i != s && cs_n[i] == 1'b0) v_cs++;
            for (int i = 0; i < NC; i++) if (i != c && sclk[i]) v_clk++;
            for (int i = 0; i < NM; i++) if (i != m && mosi[i] != NULLV) v_null++;
            if (prev_sck && sclk[c] && mosi[m] != prev_mo) v_hold++;
            if (!prev_sck && sclk[c]) begin
                if (rises == 0) lead = cyc - cs_cyc;
                else if (cyc - last_rise != 2 * HD) v_per++;
                if (rises < 8 * n && mosi[m] != pat_bit(txv, rises)) v_data++;
                last_rise = cyc;
                rises++;
            end
            if (prev_sck && !sclk[c]) begin
                sb++;
                last_fall = cyc;
                miso = (sb < 8 * n) ? pat_bit(pat, sb) : 1'b1;
            end
            if (rx_valid) begin
                chk(rx_byte == pat[8 * rxk +: 8], "R4", "received byte",
                    int'(rx_byte), int'(pat[8 * rxk +: 8]));
                rxk++;
            end
            if (done) begin
                ndone++;
                trail = cyc - last_fall;
                rel_cyc = cyc;
                chk(&cs_n, "R6", "selects high at done", int'(cs_n), (1 << NS) - 1);
            end
            prev_sck = sclk[c]; prev_mo = mosi[m];
            if (!busy && k > 0) break;
            @(negedge clk);
        end
        start = 1'b0;
        miso = 1'b1;
        if (poke_at > 0) begin
            repeat (3) begin
                @(negedge clk);
                chk((&cs_n) && !busy, "R7", "no second transaction", int'(cs_n), (1 << NS) - 1);
            end
        end
        chk(ndone == 1, "R6", "done pulses", ndone, 1);
        chk(rises == 8 * n, "R2", "rising edges", rises, 8 * n);
        chk(v_clk == 0, "R2", "other clocks toggled", v_clk, 0);
        chk(v_data == 0, "R3", "data bit errors", v_data, 0);
        chk(v_null == 0, "R3", "filler violations", v_null, 0);
        chk(v_hold == 0, "R3", "data moved while clock high", v_hold, 0);
        chk(v_cs == 0, "R1", "wrong select low", v_cs, 0);
        chk(rxk == n, "R4", "rx_valid count", rxk, n);
        chk(lead == HD, "R5", "select lead", lead, HD);
        chk(trail >= HD, "R5", "select trail", trail, HD);
        chk(v_per == 0, "R10", "clock period errors", v_per, 0);
    endtask

    task automatic run_err(input int idx, input int n);
        @(negedge clk);
        while (busy) @(negedge clk);
        dev_idx = IW'(idx); nbytes = CW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R8", "err pulse", int'(err), 1);
        chk((&cs_n) && !busy && sclk == '0 && mosi == {NM{NULLV}}, "R8",
            "lines quiet on refusal", int'(cs_n), (1 << NS) - 1);
        @(negedge clk);
        chk(err == 1'b0, "R8", "err one cycle", int'(err), 0);
        chk((&cs_n) && !busy, "R8", "no transaction after refusal", int'(busy), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        chk((&cs_n) && sclk == '0 && mosi == {NM{NULLV}} && !busy && !done && !err && !rx_valid,
            "R9", "state in reset", int'(cs_n), (1 << NS) - 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk((&cs_n) && sclk == '0 && mosi == {NM{NULLV}} && !busy, "R9",
            "state after reset", int'(mosi), (1 << NM) - 1);

        run_xfer(0, 1, 32'h0000_00A5, 32'h0000_003C, 0, 0);
        run_xfer(ND - 1, MB, 32'hFF00_FF00, 32'h00FF_00FF, 0, 0);
        run_xfer(13, 2, 32'h0000_8001, 32'h0000_7FFE, 0, 0);
        run_xfer(22, 3, 32'h00C3_5A96, 32'h0069_A53C, 9, 5);
        run_err(ND, 1);
        run_err(63, 2);
        run_err(7, 0);
        run_err(7, MB + 1);
        for (int t = 0; t < 30; t++) begin
            int idx, n;
            logic [MB*8-1:0] tv, pv;
            idx = $urandom_range(ND - 1, 0);
            n   = $urandom_range(MB, 1);
            tv  = $urandom;
            pv  = $urandom;
            run_xfer(idx, n, tv, pv, (t % 7 == 3) ? 20 : 0, $urandom_range(ND - 1, 0));
        end
        summary();
        $finish;
    end

endmodule